// File: doc/BRIEF.md
# Pulse-Swallow Programmable Feedback Divider

This block divides a fast divider clock by a ratio that can be set in steps of one. It sits in the feedback path of a frequency synthesizer, between the oscillator under control and the phase detector. Inside, a dual-modulus prescaler divides by either P+1 or P. A swallow counter decides how many prescaler periods use the larger modulus. A main counter sets how many prescaler periods make up one full division cycle. With a main value SM and a swallow value SS, one cycle lasts P*SM + SS input clocks. The output gives one pulse per cycle.

The main and swallow values come from holding latches outside the block. The block samples them only at a cycle boundary, so the length of the cycle in progress never changes part-way through. A synchronous power-down input parks the counters at a freshly loaded state and holds the output low. Two variants are chosen by parameter:

- the wide one: modulus 64/65, 6-bit swallow value, 11-bit main value;
- the narrow one: modulus 32/33, 5-bit swallow value, 10-bit main value.

Top module: `psdiv_top`

## Requirements
- R1: With PRESC=64, `main_val` is an 11-bit unsigned value and `swal_val` a 6-bit unsigned value, both binary weighted with bit 0 as the LSB. For any legal pair (5 <= SM <= 2047, SS < SM), consecutive rising edges of `div_pulse` are exactly 64*SM+SS clock cycles apart.
- R2: With PRESC=32, `main_val` is 10 bits wide and `swal_val` 5 bits wide, with the same weighting. For any legal pair (5 <= SM <= 1023, SS < SM), the pulse spacing is exactly 32*SM+SS clock cycles.
- R3: `div_pulse` is high for exactly one clock cycle per division cycle.
- R4: A value is taken into the counters only at a cycle boundary, that is, in the clock edge that raises `div_pulse`. A change of `main_val` or `swal_val` during a cycle leaves that cycle's length unchanged and sets the length of the following cycle.
- R5: While `pwr_dn` is sampled high, `div_pulse` is low in the following cycle and no pulse is produced.
- R6: After `pwr_dn` falls, the first pulse is raised by the N-th clock edge at which `pwr_dn` is sampled low, where N is the ratio of the values present during power-down.
- R7: Synchronous active-high `rst` forces `div_pulse` low. After `rst` is released, the first pulse arrives N edges later, as in R6, including when reset interrupts a cycle.
- R8: Boundary pairs give the exact ratio: SS=0 (only the base modulus is used), SS=SM-1 (the largest number of extended periods), SM=5 (the smallest main value) and the largest narrow main value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast divider clock; every rising edge is one count |
| rst | input | 1 | Synchronous active-high reset |
| pwr_dn | input | 1 | Synchronous power-down: holds the counters loaded and the output low |
| main_val | input | MN_W (11) | Main counter value SM from its holding latch |
| swal_val | input | SW_W (6) | Swallow counter value SS from its holding latch |
| div_pulse | output | 1 | One-cycle pulse at each division cycle boundary |

## Verification
The bench builds two instances side by side, one with PRESC=64 and one with PRESC=32. Both variants, their different field widths and their different moduli are therefore measured in the same run. Having the narrow variant reachable allows a main value at the top of its range (ratio 32767) within the cycle budget. It also allows both SS=0 and SS=SM-1 to be checked on each modulus. The wide instance also carries the tests of a mid-cycle value change, a long power-down and a reset in the middle of a cycle.

// File: rtl/psdiv_pkg.sv
package psdiv_pkg;

    // Prescaler modulus selection for the coming prescaler period
    typedef enum logic {
        MOD_BASE = 1'b0,   // divide by P
        MOD_WIDE = 1'b1    // divide by P+1
    } mod_sel_e;

    // Smallest main value that keeps the swallow scheme consistent
    localparam int MAIN_MIN = 5;

    // Swallow field width: one bit per binary weight below the modulus
    function automatic int swal_bits(input int presc);
        return $clog2(presc);
    endfunction

    // Main field width for the two supported variants
    function automatic int main_bits(input int presc);
        return $clog2(presc) + 5;
    endfunction

    // Width of the prescaler down-counter (must hold P)
    function automatic int pre_bits(input int presc);
        return $clog2(presc + 1);
    endfunction

endpackage

// File: rtl/psdiv_prescaler.sv
module psdiv_prescaler
    import psdiv_pkg::*;
#(
    parameter int PRESC = 64,
    parameter int PC_W  = pre_bits(PRESC)
) (
    input  logic     clk,
    input  logic     hold,
    input  mod_sel_e mod_next,
    output logic     pre_tc
);

    localparam logic [PC_W-1:0] LOAD_WIDE = PC_W'(PRESC);
    localparam logic [PC_W-1:0] LOAD_BASE = PC_W'(PRESC - 1);

    logic [PC_W-1:0] pre_cnt;

    // Terminal count ends one prescaler period
    assign pre_tc = (pre_cnt == '0);

    always_ff @(posedge clk) begin
        if (hold || pre_tc) begin
            pre_cnt <= (mod_next == MOD_WIDE) ? LOAD_WIDE : LOAD_BASE;
        end else begin
            pre_cnt <= pre_cnt - PC_W'(1);
        end
    end

endmodule

// File: rtl/psdiv_swallow.sv
module psdiv_swallow
    import psdiv_pkg::*;
#(
    parameter int SW_W = 6
) (
    input  logic            clk,
    input  logic            reload,
    input  logic            pre_tc,
    input  logic [SW_W-1:0] swal_val,
    output mod_sel_e        mod_next
);

    logic [SW_W-1:0] swal_q;
    logic [SW_W-1:0] swal_d;

    // Count down once per prescaler period until exhausted
    always_comb begin
        if (reload) begin
            swal_d = swal_val;
        end else if (pre_tc && (swal_q != '0)) begin
            swal_d = swal_q - SW_W'(1);
        end else begin
            swal_d = swal_q;
        end
        mod_next = (swal_d != '0) ? MOD_WIDE : MOD_BASE;
    end

    always_ff @(posedge clk) begin
        swal_q <= swal_d;
    end

endmodule

// File: rtl/psdiv_main.sv
module psdiv_main #(
    parameter int MN_W = 11
) (
    input  logic            clk,
    input  logic            hold,
    input  logic            pre_tc,
    input  logic [MN_W-1:0] main_val,
    output logic            cyc_end
);

    logic [MN_W-1:0] main_rem;

    // Cycle ends with the last prescaler period of the main count
    assign cyc_end = pre_tc && (main_rem == MN_W'(1));

    always_ff @(posedge clk) begin
        if (hold || cyc_end) begin
            main_rem <= main_val;
        end else if (pre_tc) begin
            main_rem <= main_rem - MN_W'(1);
        end
    end

endmodule

// File: rtl/psdiv_top.sv
module psdiv_top
    import psdiv_pkg::*;
#(
    parameter int PRESC = 64,
    parameter int SW_W  = swal_bits(PRESC),
    parameter int MN_W  = main_bits(PRESC)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pwr_dn,
    input  logic [MN_W-1:0] main_val,
    input  logic [SW_W-1:0] swal_val,
    output logic            div_pulse
);

    localparam int PC_W = pre_bits(PRESC);

    logic     hold;
    logic     pre_tc;
    logic     cyc_end;
    logic     swal_reload;
    mod_sel_e mod_next;

    assign hold        = rst || pwr_dn;
    assign swal_reload = hold || cyc_end;

    psdiv_prescaler #(
        .PRESC (PRESC),
        .PC_W  (PC_W)
    ) u_pre (
        .clk      (clk),
        .hold     (hold),
        .mod_next (mod_next),
        .pre_tc   (pre_tc)
    );

    psdiv_swallow #(
        .SW_W (SW_W)
    ) u_swl (
        .clk      (clk),
        .reload   (swal_reload),
        .pre_tc   (pre_tc),
        .swal_val (swal_val),
        .mod_next (mod_next)
    );

    psdiv_main #(
        .MN_W (MN_W)
    ) u_main (
        .clk      (clk),
        .hold     (hold),
        .pre_tc   (pre_tc),
        .main_val (main_val),
        .cyc_end  (cyc_end)
    );

    always_ff @(posedge clk) begin
        if (hold) begin
            div_pulse <= 1'b0;
        end else begin
            div_pulse <= cyc_end;
        end
    end

endmodule

// File: rtl/psdiv_chk.sv
module psdiv_chk #(
    parameter int PRESC = 64,
    parameter int SW_W  = 6,
    parameter int MN_W  = 11
) (
    input logic            clk,
    input logic            rst,
    input logic            pwr_dn,
    input logic [MN_W-1:0] main_val,
    input logic [SW_W-1:0] swal_val,
    input logic            div_pulse
);

    localparam int RW = MN_W + SW_W + 1;

    logic [RW-1:0] cur_ratio;
    logic [RW-1:0] prev_ratio;
    logic [RW-1:0] ratio_q;
    logic [RW-1:0] gap_q;

    assign cur_ratio = RW'(PRESC) * RW'(main_val) + RW'(swal_val);

    // Edges elapsed since the counters last took in latch values
    always_ff @(posedge clk) begin
        prev_ratio <= cur_ratio;
        if (rst || pwr_dn) begin
            ratio_q <= cur_ratio;
            gap_q   <= '0;
        end else if (div_pulse) begin
            ratio_q <= prev_ratio;
            gap_q   <= RW'(1);
        end else begin
            gap_q   <= gap_q + RW'(1);
        end
    end

    // R1 / R2 / R4: pulse spacing equals ratio captured at the boundary
    assert_period_exact_R1: assert property (@(posedge clk) disable iff (rst || pwr_dn)
        div_pulse |-> (gap_q == ratio_q));

    // R4: a cycle never runs past its captured ratio
    assert_no_overrun_R4: assert property (@(posedge clk) disable iff (rst || pwr_dn)
        gap_q <= ratio_q);

    // R3: one-cycle pulse
    assert_pulse_single_R3: assert property (@(posedge clk) disable iff (rst)
        div_pulse |=> !div_pulse);

    // R5: power-down silences the output
    assert_pd_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        pwr_dn |=> !div_pulse);

    // R7: reset silences the output
    assert_rst_quiet_R7: assert property (@(posedge clk)
        rst |=> !div_pulse);

endmodule

bind psdiv_top psdiv_chk #(
    .PRESC (PRESC),
    .SW_W  (SW_W),
    .MN_W  (MN_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pwr_dn    (pwr_dn),
    .main_val  (main_val),
    .swal_val  (swal_val),
    .div_pulse (div_pulse)
);

// File: tb/psdiv_top_tb.sv
module psdiv_top_tb;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic        rst;
    logic        pwr_dn;
    logic [10:0] sm_w;
    logic [5:0]  ss_w;
    logic [9:0]  sm_n;
    logic [4:0]  ss_n;
    logic        p_w;
    logic        p_n;

    int checks = 0;
    int fails  = 0;

    psdiv_top #(.PRESC(64)) u_dut (
        .clk(clk), .rst(rst), .pwr_dn(pwr_dn),
        .main_val(sm_w), .swal_val(ss_w), .div_pulse(p_w)
    );

    psdiv_top #(.PRESC(32)) u_dut32 (
        .clk(clk), .rst(rst), .pwr_dn(pwr_dn),
        .main_val(sm_n), .swal_val(ss_n), .div_pulse(p_n)
    );

    // Vectors: variant (0 = 64/65, 1 = 32/33), SM, SS, expected ratio
    localparam int NV = 9;
    localparam int T_V [NV] = '{0, 0, 0, 0, 0, 1, 1, 1, 1};
    localparam int T_SM[NV] = '{5, 5, 10, 7, 100, 5, 9, 1023, 200};
    localparam int T_SS[NV] = '{0, 4, 3, 6, 63, 0, 8, 31, 17};
    localparam int T_N [NV] = '{320, 324, 643, 454, 6463, 160, 296, 32767, 6417};

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic pulse_of(input int v);
        return (v != 0) ? p_n : p_w;
    endfunction

    // Count negedges until the selected pulse is seen high
    task automatic wait_pulse(input int v, output int cnt);
        cnt = 0;
        do begin
            @(negedge clk);
            cnt++;
        end while (pulse_of(v) != 1'b1);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        int cnt;
        int hits;
        rst    = 1'b1;
        pwr_dn = 1'b0;
        sm_w = 11'd5;  ss_w = 6'd0;
        sm_n = 10'd5;  ss_n = 5'd0;
        repeat (4) @(negedge clk);
        chk("R7 reset state wide", int'(p_w), 0);
        chk("R7 reset state narrow", int'(p_n), 0);

        // R7: first pulse N edges after reset release
        rst = 1'b0;
        wait_pulse(0, cnt);
        chk("R7 first pulse after reset", cnt, 320);

        // Vector table: R1 (wide), R2 (narrow), R3, R5, R6, R8 boundaries
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            if (T_V[i] == 0) begin
                sm_w = 11'(T_SM[i]); ss_w = 6'(T_SS[i]);
            end else begin
                sm_n = 10'(T_SM[i]); ss_n = 5'(T_SS[i]);
            end
            pwr_dn = 1'b1;
            repeat (2) @(negedge clk);
            chk("R5 output low in power-down", int'(pulse_of(T_V[i])), 0);
            pwr_dn = 1'b0;
            wait_pulse(T_V[i], cnt);
            chk("R6 first pulse after power-down", cnt, T_N[i]);
            @(negedge clk);
            chk("R3 pulse one cycle wide", int'(pulse_of(T_V[i])), 0);
            wait_pulse(T_V[i], cnt);
            // rows with SS=0, SS=SM-1, SM=5 and SM=1023 cover R8
            chk((T_V[i] == 0) ? "R1 R8 wide ratio" : "R2 R8 narrow ratio", cnt + 1, T_N[i]);
        end

        // R5: long power-down produces no pulse at all
        @(negedge clk);
        sm_w = 11'd5; ss_w = 6'd0;
        pwr_dn = 1'b1;
        hits = 0;
        for (int k = 0; k < 700; k++) begin
            @(negedge clk);
            if (p_w) hits++;
        end
        chk("R5 no pulses during long power-down", hits, 0);
        pwr_dn = 1'b0;
        wait_pulse(0, cnt);
        chk("R6 restart after long power-down", cnt, 320);

        // R4: mid-cycle change affects only the next cycle
        @(negedge clk);
        sm_w = 11'd10; ss_w = 6'd3;
        pwr_dn = 1'b1;
        repeat (2) @(negedge clk);
        pwr_dn = 1'b0;
        wait_pulse(0, cnt);
        chk("R6 start for R4 test", cnt, 643);
        repeat (5) @(negedge clk);
        sm_w = 11'd6; ss_w = 6'd2;
        wait_pulse(0, cnt);
        chk("R4 current cycle keeps old ratio", cnt + 5, 643);
        wait_pulse(0, cnt);
        chk("R4 next cycle uses new ratio", cnt, 386);

        // R7: reset in the middle of a cycle restarts the count cleanly
        repeat (100) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R7 output low under reset", int'(p_w), 0);
        rst = 1'b0;
        wait_pulse(0, cnt);
        chk("R7 first pulse after mid-cycle reset", cnt, 386);

        summary();
        $finish;
    end

endmodule